// File: doc/BRIEF.md
# Status-Polled Flash Bank Erase and Program Sequencer

This block controls a byte-wide parallel flash that uses a command and status-register protocol. A single request erases one bank or programs one bank. For a program request, the bytes come from a source buffer that the block reads through its own address port. Every command byte goes out on a simple synchronous flash bus. After each command that starts an internal operation, the block writes a status command and reads the status byte back. It keeps polling until the device reports ready, and it gives up after a fixed number of attempts.

Each request ends with the same pair of writes: one clears the device status and the other returns the device to array-read mode. If polling finished cleanly, the block then reads the whole bank back. It checks each byte against 0xFF after an erase, or against the source buffer after a program. A one-cycle `done` pulse closes the request, and `err` tells whether anything went wrong.

A bank is 2^BANK_AW bytes. Its flash base address is the bank index shifted left by BANK_AW. Flash read data and source-buffer read data are both taken one cycle after the strobe or address that requested them.

Top module: `flash_seq`

## Requirements
- R1: An erase request (op=0) writes 0x20 and then 0xD0 to the bank base address on two consecutive cycles, starting the cycle after `start` is seen.
- R2: Each status poll writes 0x70 to the bank base, reads the bank base on the next cycle, and judges the byte returned one cycle later. Bit 7 set means ready. When the device is not ready, one idle cycle follows before the next 0x70 write.
- R3: A program request (op=1) handles bytes in ascending order. For byte i it writes 0x40 to base+i, leaves exactly GAP_CYCLES cycles with no strobe, writes the source byte i to base+i, and then polls as in R2. The next byte's 0x40 write follows one idle cycle after the ready status.
- R4: If POLL_LIMIT consecutive status reads in one wait all lack bit 7, polling stops and `err` is reported. A program request stops at that byte, and no verify runs.
- R5: Fault bits 5:3 (mask 0x38) are examined only on a ready status. If any of them is set, `err` is reported, no further byte is programmed, and no verify runs.
- R6: Every request ends with a write of 0x50 and then a write of 0xFF to the bank base, on consecutive cycles. The first of these follows one idle cycle after the final status read.
- R7: After clean polling, bytes base+0 to base+2^BANK_AW-1 are read in order with one idle cycle between reads. `err` is set if any erased byte is not 0xFF, or if any programmed byte differs from the source.
- R8: `busy` goes high the cycle after `start` is accepted. `done` is high for exactly one cycle, `busy` is low on the cycle after it, and `err` is valid while `done` is high.
- R9: A `start` seen while `busy` is high is ignored. It causes no extra bus activity and no second `done`.
- R10: `fl_we` and `fl_re` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 1 | 0 = erase bank, 1 = program bank |
| bank | input | BANK_BITS | Bank index |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| fl_addr | output | BANK_BITS+BANK_AW | Flash byte address |
| fl_wdata | output | 8 | Flash write data or command |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, one cycle after fl_re |
| buf_addr | output | BANK_AW | Source buffer byte index |
| buf_rdata | input | 8 | Source buffer data, one cycle after buf_addr |

## Verification
The bus sequence is exercised under several device responses:
- Status ready on the first poll, and a few busy polls. These separate the single-read path from the repeat-poll path and its idle cycle.
- Busy for exactly POLL_LIMIT-1 polls, which must succeed, and for POLL_LIMIT polls, which must time out. Together they pin the attempt count.
- Fault bits raised only while the device is busy, and then again on a ready status. These show that faults are judged only when the device is ready.
- A program timeout partway through the bank. This shows that programming stops at that byte.
- A stuck byte after an erase and another after a program. These show that a failed byte is caught only by the read-back.
- A second `start` during a running request, which must be ignored.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ESETUP,
      S_ECONF,
      S_PSETUP,
      S_PGAP,
      S_PDATA,
      S_PCMD,
      S_PRD,
      S_PCHK,
      S_CLR,
      S_RST,
      S_VRD,
      S_VCHK,
      S_DONE
   } seq_st_t;

   typedef enum logic {
      OP_ERASE = 1'b0,
      OP_PROG  = 1'b1
   } seq_op_t;

   localparam logic [7:0] C_ERS_ARM   = 8'h20;
   localparam logic [7:0] C_ERS_GO    = 8'hD0;
   localparam logic [7:0] C_PGM_ARM   = 8'h40;
   localparam logic [7:0] C_STAT_RD   = 8'h70;
   localparam logic [7:0] C_STAT_CLR  = 8'h50;
   localparam logic [7:0] C_READ_MODE = 8'hFF;
   localparam logic [7:0] BLANK_BYTE  = 8'hFF;
   localparam logic [7:0] FAULT_MASK  = 8'h38;
   localparam int         READY_BIT   = 7;

endpackage

// File: rtl/flseq_gap_timer.sv
module flseq_gap_timer #(
   parameter int CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   if (CYCLES < 0) begin : g_bad_cycles
      $error("flseq_gap_timer: CYCLES must not be negative");
   end

   if (CYCLES == 0) begin : g_none
      assign expired = 1'b1;
   end else begin : g_count
      localparam int W = $clog2(CYCLES + 1);
      localparam logic [W-1:0] INIT = W'(CYCLES - 1);
      logic [W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (load)
            cnt <= INIT;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end

      assign expired = (cnt == '0);

      p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= INIT);
   end

endmodule

// File: rtl/flseq_poll_ctr.sv
module flseq_poll_ctr #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic last
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("flseq_poll_ctr: LIMIT must be at least 1");
   end

   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST_CNT = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   assign last = (cnt == LAST_CNT);

   // R4: the sequencer never asks for another attempt once the limit is reached
   p_step_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !last);

   p_attempts_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_CNT);

endmodule

// File: rtl/flseq_judge.sv
module flseq_judge
   import flseq_pkg::*;
(
   input  logic       op_prog,
   input  logic [7:0] rd_byte,
   input  logic [7:0] src_byte,
   output logic       ready,
   output logic       fault,
   output logic       mismatch
);

   logic [7:0] want;

   always_comb begin
      ready    = rd_byte[READY_BIT];
      fault    = |(rd_byte & FAULT_MASK);
      want     = op_prog ? src_byte : BLANK_BYTE;
      mismatch = (rd_byte != want);
   end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flseq_pkg::*;
#(
   parameter int BANK_AW    = 13,
   parameter int BANK_BITS  = 1,
   parameter int POLL_LIMIT = 1000000,
   parameter int GAP_CYCLES = 50
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         op,
   input  logic [BANK_BITS-1:0]         bank,
   output logic                         busy,
   output logic                         done,
   output logic                         err,
   output logic [BANK_BITS+BANK_AW-1:0] fl_addr,
   output logic [7:0]                   fl_wdata,
   output logic                         fl_we,
   output logic                         fl_re,
   input  logic [7:0]                   fl_rdata,
   output logic [BANK_AW-1:0]           buf_addr,
   input  logic [7:0]                   buf_rdata
);

   if (BANK_AW < 1) begin : g_bad_aw
      $error("flash_seq: BANK_AW must be at least 1");
   end
   if (BANK_BITS < 1) begin : g_bad_bank
      $error("flash_seq: BANK_BITS must be at least 1");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("flash_seq: POLL_LIMIT must be at least 1");
   end
   if (GAP_CYCLES < 0) begin : g_bad_gap
      $error("flash_seq: GAP_CYCLES must not be negative");
   end

   localparam int FA_W = BANK_BITS + BANK_AW;
   localparam logic [BANK_AW-1:0] LAST_IDX = '1;
   localparam bit HAS_GAP = (GAP_CYCLES > 0);

   seq_st_t              st, st_nx;
   seq_op_t              op_q;
   logic [BANK_BITS-1:0] bank_q;
   logic [BANK_AW-1:0]   idx;
   logic                 err_q;

   logic ready, fault, mismatch;
   logic gap_expired, poll_last;
   logic [BANK_AW-1:0] off;

   flseq_judge u_judge (
      .op_prog  (op_q == OP_PROG),
      .rd_byte  (fl_rdata),
      .src_byte (buf_rdata),
      .ready    (ready),
      .fault    (fault),
      .mismatch (mismatch)
   );

   flseq_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (st == S_PSETUP),
      .expired (gap_expired)
   );

   flseq_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((st == S_ECONF) || (st == S_PDATA)),
      .step  ((st == S_PCHK) && !ready && !poll_last),
      .last  (poll_last)
   );

   // next state
   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:   if (start) st_nx = op ? S_PSETUP : S_ESETUP;
         S_ESETUP: st_nx = S_ECONF;
         S_ECONF:  st_nx = S_PCMD;
         S_PSETUP: st_nx = HAS_GAP ? S_PGAP : S_PDATA;
         S_PGAP:   if (gap_expired) st_nx = S_PDATA;
         S_PDATA:  st_nx = S_PCMD;
         S_PCMD:   st_nx = S_PRD;
         S_PRD:    st_nx = S_PCHK;
         S_PCHK: begin
            if (ready) begin
               if (fault || op_q == OP_ERASE || idx == LAST_IDX)
                  st_nx = S_CLR;
               else
                  st_nx = S_PSETUP;
            end else begin
               st_nx = poll_last ? S_CLR : S_PCMD;
            end
         end
         S_CLR:    st_nx = S_RST;
         S_RST:    st_nx = err_q ? S_DONE : S_VRD;
         S_VRD:    st_nx = S_VCHK;
         S_VCHK:   st_nx = (idx == LAST_IDX) ? S_DONE : S_VRD;
         S_DONE:   st_nx = S_IDLE;
         default:  st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         op_q   <= OP_ERASE;
         bank_q <= '0;
         idx    <= '0;
         err_q  <= 1'b0;
      end else begin
         st <= st_nx;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  op_q   <= seq_op_t'(op);
                  bank_q <= bank;
                  idx    <= '0;
                  err_q  <= 1'b0;
               end
            end
            S_PCHK: begin
               if (ready) begin
                  if (fault)
                     err_q <= 1'b1;
                  else if (op_q == OP_PROG && idx != LAST_IDX)
                     idx <= idx + 1'b1;
               end else if (poll_last) begin
                  err_q <= 1'b1;
               end
            end
            S_RST: idx <= '0;
            S_VCHK: begin
               if (mismatch)
                  err_q <= 1'b1;
               if (idx != LAST_IDX)
                  idx <= idx + 1'b1;
            end
            default: ;
         endcase
      end
   end

   // bus drive, decoded from state
   always_comb begin
      unique case (st)
         S_PSETUP, S_PGAP, S_PDATA, S_VRD, S_VCHK: off = idx;
         default:                                  off = '0;
      endcase
   end

   assign fl_addr  = {bank_q, off};
   assign buf_addr = idx;

   always_comb begin
      unique case (st)
         S_ESETUP: fl_wdata = C_ERS_ARM;
         S_ECONF:  fl_wdata = C_ERS_GO;
         S_PSETUP: fl_wdata = C_PGM_ARM;
         S_PDATA:  fl_wdata = buf_rdata;
         S_PCMD:   fl_wdata = C_STAT_RD;
         S_CLR:    fl_wdata = C_STAT_CLR;
         S_RST:    fl_wdata = C_READ_MODE;
         default:  fl_wdata = 8'h00;
      endcase
   end

   assign fl_we = (st == S_ESETUP) || (st == S_ECONF) || (st == S_PSETUP) ||
                  (st == S_PDATA)  || (st == S_PCMD)  || (st == S_CLR)    ||
                  (st == S_RST);
   assign fl_re = (st == S_PRD) || (st == S_VRD);

   assign busy = (st != S_IDLE);
   assign done = (st == S_DONE);
   assign err  = err_q;

   // ---------------- assertions ----------------
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fl_we && !fl_re));

   p_confirm_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ESETUP) |=> (fl_we && fl_wdata == C_ERS_GO && $stable(fl_addr)));

   p_status_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PCMD) |=> (fl_re && $stable(fl_addr)));

   p_gap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PGAP) |-> (!fl_we && !fl_re));

   p_close_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CLR) |=> (fl_we && fl_wdata == C_READ_MODE && $stable(fl_addr)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(op_q) && $stable(bank_q)));

endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;

   localparam int BAW   = 4;
   localparam int BANK  = 1 << BAW;
   localparam int LIMIT = 6;
   localparam int GAP   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       op = 1'b0;
   logic [0:0] bnk = 1'b0;
   logic       busy, done, err;
   logic [BAW:0]   fl_addr;
   logic [7:0]     fl_wdata;
   logic           fl_we, fl_re;
   logic [7:0]     fl_rdata = 8'h00;
   logic [BAW-1:0] buf_addr;
   logic [7:0]     buf_rdata = 8'h00;

   always #10 clk = ~clk;

   flash_seq #(.BANK_AW(BAW), .BANK_BITS(1), .POLL_LIMIT(LIMIT), .GAP_CYCLES(GAP)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bnk),
      .busy(busy), .done(done), .err(err),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
      .fl_rdata(fl_rdata), .buf_addr(buf_addr), .buf_rdata(buf_rdata)
   );

   typedef struct {
      bit    rd;
      int    addr;
      int    data;
      int    gap;
      string req;
   } exp_t;

   exp_t q[$];

   int n_cmp = 0;
   int n_bad = 0;

   // device knobs
   int k_busy = 0;
   int k_to_byte = -1;
   int k_err_byte = -1;
   int k_prog_stuck = -1;
   int k_erase_stuck = -1;
   int k_fval = 8'h10;
   bit exp_err;

   logic [7:0] src [0:BANK-1];
   logic [7:0] mem [0:2*BANK-1] = '{default: 8'h00};

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic int busy_for(int i);
      return (i == k_to_byte) ? 100 : k_busy;
   endfunction

   task automatic push(bit rd, int addr, int data, int gap, string req);
      exp_t e;
      e.rd = rd; e.addr = addr; e.data = data; e.gap = gap; e.req = req;
      q.push_back(e);
   endtask

   task automatic gen_poll(int base, int n, output bit tout);
      int att;
      att = (n + 1 > LIMIT) ? LIMIT : n + 1;
      for (int a = 0; a < att; a++) begin
         push(0, base, 8'h70, (a == 0) ? 0 : 1, "R2");
         push(1, base, 0, 0, "R2");
      end
      tout = (n + 1 > LIMIT);
   endtask

   task automatic gen_close(int base);
      push(0, base, 8'h50, 1, "R6");
      push(0, base, 8'hFF, 0, "R6");
   endtask

   task automatic gen_verify(int base);
      for (int i = 0; i < BANK; i++)
         push(1, base + i, 0, (i == 0) ? 0 : 1, "R7");
   endtask

   task automatic gen_erase(int bankn);
      int base;
      bit tout;
      base = bankn * BANK;
      exp_err = 0;
      push(0, base, 8'h20, -1, "R1");
      push(0, base, 8'hD0, 0, "R1");
      gen_poll(base, k_busy, tout);
      gen_close(base);
      if (tout || k_err_byte >= 0) exp_err = 1;
      else begin
         gen_verify(base);
         if (k_erase_stuck >= 0) exp_err = 1;
      end
   endtask

   task automatic gen_prog(int bankn);
      int base;
      bit tout;
      bit stop;
      base = bankn * BANK;
      exp_err = 0;
      stop = 0;
      for (int i = 0; i < BANK && !stop; i++) begin
         push(0, base + i, 8'h40, (i == 0) ? -1 : 1, "R3");
         push(0, base + i, int'(src[i]), GAP, "R3");
         gen_poll(base, busy_for(i), tout);
         if (tout || i == k_err_byte) stop = 1;
      end
      gen_close(base);
      if (stop) exp_err = 1;
      else begin
         gen_verify(base);
         if (k_prog_stuck >= 0) exp_err = 1;
      end
   endtask

   // bus reference check and device model, one process at the falling edge
   int idle = 0;
   bit f_status = 0, f_pend_erase = 0, f_pend_prog = 0, f_fault = 0;
   int f_busy = 0;

   always @(negedge clk) begin
      exp_t e;
      int a, off, bb;
      if (rst_n && (fl_we || fl_re)) begin
         a = int'(fl_addr);
         chk(!(fl_we && fl_re), "R10", "both strobes", 1, 0);
         if (q.size() == 0) begin
            chk(0, "R10", "unexpected strobe at addr", a, 0);
         end else begin
            e = q.pop_front();
            chk(e.rd == fl_re, e.req, "strobe kind (1=read)", int'(fl_re), int'(e.rd));
            chk(e.addr == a, e.req, "address", a, e.addr);
            if (!e.rd) chk(e.data == int'(fl_wdata), e.req, "write data", int'(fl_wdata), e.data);
            if (e.gap >= 0) chk(e.gap == idle, e.req, "idle cycles before strobe", idle, e.gap);
         end
         idle = 0;
         off = a % BANK;
         bb = a - off;
         if (fl_we) begin
            if (f_pend_prog) begin
               if (off != k_prog_stuck) mem[a] = fl_wdata;
               f_pend_prog = 0;
               f_busy = busy_for(off);
               f_fault = (off == k_err_byte);
               f_status = 1;
            end else begin
               case (fl_wdata)
                  8'h20: f_pend_erase = 1;
                  8'hD0: if (f_pend_erase) begin
                     for (int j = 0; j < BANK; j++)
                        mem[bb + j] = (j == k_erase_stuck) ? 8'h00 : 8'hFF;
                     f_busy = k_busy;
                     f_fault = (k_err_byte >= 0);
                     f_status = 1;
                     f_pend_erase = 0;
                  end
                  8'h40: f_pend_prog = 1;
                  8'h70: f_status = 1;
                  8'h50: f_fault = 0;
                  8'hFF: f_status = 0;
                  default: ;
               endcase
            end
         end else begin
            if (f_status) begin
               if (f_busy > 0) begin
                  f_busy--;
                  fl_rdata = 8'h38;
               end else begin
                  fl_rdata = 8'h80 | (f_fault ? k_fval[7:0] : 8'h00);
               end
            end else begin
               fl_rdata = mem[a];
            end
         end
      end else begin
         idle++;
      end
      buf_rdata = src[buf_addr];
   end

   task automatic run_op(bit is_prog, int bankn, bit poke, string tag);
      int w;
      q.delete();
      if (is_prog) gen_prog(bankn); else gen_erase(bankn);
      @(negedge clk);
      start = 1'b1; op = is_prog; bnk = bankn[0];
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
      if (poke) begin
         repeat (2) @(negedge clk);
         start = 1'b1; op = !is_prog; bnk = ~bnk;
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (done !== 1'b1 && w < 5000) begin
         @(negedge clk);
         w++;
      end
      chk(done === 1'b1, "R8", "done seen", int'(done), 1);
      chk(err === exp_err, tag, "err at done", int'(err), int'(exp_err));
      chk(q.size() == 0, tag, "strobes still expected", q.size(), 0);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R8", "done/busy after pulse", int'({done, busy}), 0);
      if (poke) begin
         repeat (6) @(negedge clk);
         chk(busy === 1'b0 && done === 1'b0, "R9", "second start ignored, busy/done", int'({busy, done}), 0);
      end
   endtask

   task automatic knobs_clear();
      k_busy = 0; k_to_byte = -1; k_err_byte = -1;
      k_prog_stuck = -1; k_erase_stuck = -1; k_fval = 8'h10;
   endtask

   task automatic fill_src(int mul, int add);
      for (int i = 0; i < BANK; i++) src[i] = 8'((i * mul + add) % 255);
   endtask

   initial begin
      fill_src(37, 5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R8", "reset outputs", int'({busy, done, err}), 0);
      chk(fl_we === 1'b0 && fl_re === 1'b0, "R10", "reset strobes", int'({fl_we, fl_re}), 0);

      // R1 R2 R7: erase with short busy
      knobs_clear(); k_busy = 2;
      run_op(0, 0, 0, "R1");
      // R3 R7: program, ready at first poll
      knobs_clear(); fill_src(37, 5);
      run_op(1, 0, 0, "R3");
      // R2 boundary: busy for LIMIT-1 polls still succeeds
      knobs_clear(); k_busy = LIMIT - 1;
      run_op(0, 1, 0, "R4");
      // R9: second start during program
      knobs_clear(); k_busy = 1; fill_src(11, 200);
      run_op(1, 1, 1, "R9");
      // R4: erase timeout at exactly LIMIT busy polls
      knobs_clear(); k_busy = LIMIT;
      run_op(0, 0, 0, "R4");
      // R5: fault on ready status during program stops at byte 5
      knobs_clear(); k_err_byte = 5; k_fval = 8'h20; fill_src(5, 1);
      run_op(1, 0, 0, "R5");
      // R4: program timeout at byte 3
      knobs_clear(); k_to_byte = 3; fill_src(3, 9);
      run_op(1, 1, 0, "R4");
      // R7: program with stuck byte found only in read-back
      knobs_clear(); k_prog_stuck = 9; k_busy = 1; fill_src(13, 17);
      run_op(1, 0, 0, "R7");
      // R7: erase with stuck byte
      knobs_clear(); k_erase_stuck = 7;
      run_op(0, 1, 0, "R7");
      // R5: erase with fault bit 3 on ready status
      knobs_clear(); k_err_byte = 0; k_fval = 8'h08; k_busy = 1;
      run_op(0, 0, 0, "R5");
      // R6 R7: clean erase and program after failures
      knobs_clear();
      run_op(0, 1, 0, "R6");
      knobs_clear(); k_busy = 2; fill_src(29, 40);
      run_op(1, 1, 0, "R7");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: done actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule